// File: doc/BRIEF.md
# Dual Frequency-Offset History Filter

This block smooths a stream of signed fractional-frequency-offset samples into two histories at once. A short-term chain tracks recent behaviour with a small time constant. A long-term chain averages over a much longer window and serves as the device history for holdover. Each chain is a third-order low-pass filter built from three cascaded first-order IIR stages. Both chains advance on every sample strobe, whatever the operating mode.

The long-term history is marked developed once enough samples have been taken since reset or since the last history clear. A selector produces the holdover offset from one of two sources, chosen by a select bit: the developed device history or a user-programmed word. If the device history is selected before it has developed, the holdover offset is zero. A synchronous clear input restarts both histories.

Top module: `freq_history_filter`

## Requirements
- R1: After reset, short_hist, long_hist, long_ready and holdover_out are all zero.
- R2: Each chain has three stages, each holding 40 bits: the 24-bit offset followed by 16 fraction bits. On a strobe, stage 0 does y += (x - y) >>> k, where x is smp_offset with 16 zero fraction bits appended. Stages 1 and 2 do the same, each taking the value the previous stage held before this strobe as x. A history output is stage 2 shifted right arithmetically by 16, and it appears on the cycle after the strobe.
- R3: The short chain uses k_short and the long chain uses k_long. A shift setting of 0 acts as 1.
- R4: On a cycle with no strobe and no clear, short_hist and long_hist keep their values.
- R5: A saturating 16-bit counter counts strobes. long_ready goes high one cycle after the count reaches 2^k_long, using the effective shift. It stays high while the count is at or above that level.
- R6: holdover_out is registered with one cycle of delay. It equals user_hist when use_user is 1. Otherwise it equals long_hist when long_ready is 1, and zero when long_ready is 0.
- R7: On a cycle with hist_clr high, all six stages and the counter go to zero, and long_ready goes low on the next edge. The clear takes priority over a strobe in the same cycle.
- R8: Both chains update on every strobe for any value of use_user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hist_clr | input | 1 | Synchronous clear of both histories and the sample count |
| smp_valid | input | 1 | Sample strobe |
| smp_offset | input | 24 | Signed offset sample |
| k_short | input | 4 | Shift setting of the short-term chain |
| k_long | input | 4 | Shift setting of the long-term chain |
| use_user | input | 1 | 1 selects the user history for holdover |
| user_hist | input | 24 | User-programmed holdover offset |
| short_hist | output | 24 | Short-term history |
| long_hist | output | 24 | Long-term history |
| long_ready | output | 1 | Long-term history has developed |
| holdover_out | output | 24 | Selected holdover offset |

## Verification
The histories change on the edge that takes the strobe, so they are compared half a cycle after that edge. long_ready lags the sample counter by one edge, and holdover_out lags long_hist and long_ready by one more edge. The bench keeps a reference state in which every register is updated from the previous values at each rising edge. It drives inputs at the falling edge and compares all four outputs at the next falling edge, so each result is checked in the cycle it becomes due.

// File: rtl/fhf_pkg.sv
package fhf_pkg;
  localparam int OFS_W   = 24;
  localparam int GUARD_W = 16;
  localparam int ACC_W   = OFS_W + GUARD_W;
  localparam int SHIFT_W = 4;
  localparam int CNT_W   = 16;
  localparam int ORDER   = 3;
endpackage

// File: rtl/fhf_iir_stage.sv
module fhf_iir_stage #(
  parameter int W  = 40,
  parameter int KW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din,
  input  logic [KW-1:0]       k,
  output logic signed [W-1:0] q
);
  logic signed [W:0] diff, step, sum;

  always_comb begin
    diff = {din[W-1], din} - {q[W-1], q};
    step = diff >>> k;
    sum  = {q[W-1], q} + step;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= sum[W-1:0];
  end
endmodule

// File: rtl/fhf_chain.sv
module fhf_chain #(
  parameter int W      = 40,
  parameter int KW     = 4,
  parameter int STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din,
  input  logic [KW-1:0]       k,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] tap [STAGES+1];

  assign tap[0] = din;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    fhf_iir_stage #(.W(W), .KW(KW)) u_stage (
      .clk(clk), .rst(rst), .clr(clr), .en(en),
      .din(tap[i]), .k(k), .q(tap[i+1])
    );
  end

  assign dout = tap[STAGES];
endmodule

// File: rtl/fhf_age.sv
module fhf_age #(
  parameter int CW = 16,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [KW-1:0] k,
  output logic          ready
);
  logic [CW-1:0] cnt;
  logic [CW:0]   target;

  assign target = (CW+1)'(1) << k;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (en && cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
      ready <= ({1'b0, cnt} >= target);
    end
  end
endmodule

// File: rtl/fhf_holdover_sel.sv
module fhf_holdover_sel #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         use_user,
  input  logic         dev_ready,
  input  logic [W-1:0] dev_hist,
  input  logic [W-1:0] user_hist,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst)            hold <= '0;
    else if (use_user)  hold <= user_hist;
    else if (dev_ready) hold <= dev_hist;
    else                hold <= '0;
  end
endmodule

// File: rtl/freq_history_filter.sv
module freq_history_filter
  import fhf_pkg::*;
#(
  parameter int DW = OFS_W,
  parameter int GW = GUARD_W,
  parameter int KW = SHIFT_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hist_clr,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_offset,
  input  logic [KW-1:0] k_short,
  input  logic [KW-1:0] k_long,
  input  logic          use_user,
  input  logic [DW-1:0] user_hist,
  output logic [DW-1:0] short_hist,
  output logic [DW-1:0] long_hist,
  output logic          long_ready,
  output logic [DW-1:0] holdover_out
);
  localparam int AW = DW + GW;

  logic signed [AW-1:0] x_ext, s_acc, l_acc;
  logic [KW-1:0]        ks_eff, kl_eff;

  assign x_ext  = {smp_offset, {GW{1'b0}}};
  assign ks_eff = (k_short == '0) ? KW'(1) : k_short;
  assign kl_eff = (k_long  == '0) ? KW'(1) : k_long;

  fhf_chain #(.W(AW), .KW(KW), .STAGES(ORDER)) u_short (
    .clk(clk), .rst(rst), .clr(hist_clr), .en(smp_valid),
    .din(x_ext), .k(ks_eff), .dout(s_acc)
  );

  fhf_chain #(.W(AW), .KW(KW), .STAGES(ORDER)) u_long (
    .clk(clk), .rst(rst), .clr(hist_clr), .en(smp_valid),
    .din(x_ext), .k(kl_eff), .dout(l_acc)
  );

  assign short_hist = s_acc[AW-1:GW];
  assign long_hist  = l_acc[AW-1:GW];

  fhf_age #(.CW(CW), .KW(KW)) u_age (
    .clk(clk), .rst(rst), .clr(hist_clr), .en(smp_valid),
    .k(kl_eff), .ready(long_ready)
  );

  fhf_holdover_sel #(.W(DW)) u_sel (
    .clk(clk), .rst(rst), .use_user(use_user), .dev_ready(long_ready),
    .dev_hist(long_hist), .user_hist(user_hist), .hold(holdover_out)
  );
endmodule

// File: rtl/fhf_checker.sv
module fhf_checker #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          hist_clr,
  input logic          smp_valid,
  input logic          use_user,
  input logic [DW-1:0] user_hist,
  input logic [DW-1:0] short_hist,
  input logic [DW-1:0] long_hist,
  input logic          long_ready,
  input logic [DW-1:0] holdover_out
);
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    hist_clr |=> (short_hist == '0 && long_hist == '0));

  a_r7_clear_drops_ready: assert property (@(posedge clk) disable iff (rst)
    hist_clr |=> ##1 !long_ready);

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !hist_clr) |=> ($stable(short_hist) && $stable(long_hist)));

  a_r6_user_path: assert property (@(posedge clk) disable iff (rst)
    use_user |=> holdover_out == $past(user_hist));

  a_r6_undeveloped_zero: assert property (@(posedge clk) disable iff (rst)
    (!use_user && !long_ready) |=> holdover_out == '0);

  a_r6_device_path: assert property (@(posedge clk) disable iff (rst)
    (!use_user && long_ready) |=> holdover_out == $past(long_hist));
endmodule

bind freq_history_filter fhf_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .hist_clr(hist_clr), .smp_valid(smp_valid),
  .use_user(use_user), .user_hist(user_hist), .short_hist(short_hist),
  .long_hist(long_hist), .long_ready(long_ready), .holdover_out(holdover_out)
);

// File: tb/sim_freq_history_filter.sv
module sim_freq_history_filter;
  localparam int PERIOD = 10;
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst, hist_clr, smp_valid, use_user;
  logic [23:0] smp_offset, user_hist;
  logic [3:0]  k_short, k_long;
  logic [23:0] short_hist, long_hist, holdover_out;
  logic        long_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  longint ms [2][3];
  int     mcnt;
  bit     mready;
  logic [23:0] mhold;

  always #(PERIOD/2) clk = ~clk;

  freq_history_filter u0 (
    .clk(clk), .rst(rst), .hist_clr(hist_clr), .smp_valid(smp_valid),
    .smp_offset(smp_offset), .k_short(k_short), .k_long(k_long),
    .use_user(use_user), .user_hist(user_hist), .short_hist(short_hist),
    .long_hist(long_hist), .long_ready(long_ready), .holdover_out(holdover_out)
  );

  function automatic int keff(logic [3:0] k);
    return (k == 0) ? 1 : int'(k);
  endfunction

  function automatic longint step(longint y, longint x, int k);
    return y + ((x - y) >>> k);
  endfunction

  function automatic logic [23:0] hist_of(longint a);
    return 24'(a >>> 16);
  endfunction

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) for (int s = 0; s < 3; s++) ms[c][s] = 0;
    mcnt = 0; mready = 0; mhold = '0;
  endtask

  // Advance the reference by one rising edge, using pre-edge values.
  task automatic model_edge();
    logic [23:0] lh_old;
    bit          rd_old;
    longint      x, prev [3];
    int          kk;
    lh_old = hist_of(ms[1][2]);
    rd_old = mready;
    if (use_user)    mhold = user_hist;
    else if (rd_old) mhold = lh_old;
    else             mhold = '0;
    if (hist_clr) begin
      for (int c = 0; c < 2; c++) for (int s = 0; s < 3; s++) ms[c][s] = 0;
      mcnt = 0; mready = 0;
    end else begin
      mready = (mcnt >= (1 << keff(k_long)));
      if (smp_valid) begin
        x = longint'($signed(smp_offset)) <<< 16;
        for (int c = 0; c < 2; c++) begin
          kk = keff(c == 0 ? k_short : k_long);
          for (int s = 0; s < 3; s++) prev[s] = ms[c][s];
          ms[c][0] = step(prev[0], x, kk);
          ms[c][1] = step(prev[1], prev[0], kk);
          ms[c][2] = step(prev[2], prev[1], kk);
        end
        if (mcnt < 65535) mcnt++;
      end
    end
  endtask

  task automatic cyc(bit v, logic [23:0] off, bit clr, bit uu, logic [23:0] uh, string tag);
    smp_valid = v; smp_offset = off; hist_clr = clr; use_user = uu; user_hist = uh;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " short_hist"}, short_hist, hist_of(ms[0][2]));
    chk({tag, " long_hist"},  long_hist,  hist_of(ms[1][2]));
    chk("R5 long_ready", {23'd0, long_ready}, {23'd0, mready});
    chk("R6 holdover_out", holdover_out, mhold);
  endtask

  initial begin
    #(PERIOD * WATCHDOG);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(20240611);
    rst = 1; hist_clr = 0; smp_valid = 0; smp_offset = '0; use_user = 0;
    user_hist = '0; k_short = 4'd2; k_long = 4'd3;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 short_hist", short_hist, '0);
    chk("R1 long_hist", long_hist, '0);
    chk("R1 long_ready", {23'd0, long_ready}, '0);
    chk("R1 holdover_out", holdover_out, '0);
    rst = 0;

    // R2 R3: step response, ready after 8 strobes (R5)
    for (int i = 0; i < 20; i++) cyc(1, 24'd100000, 0, 0, 24'h123456, "R2");
    // R4: idle cycles hold
    for (int i = 0; i < 5; i++) cyc(0, 24'hABCDEF, 0, 0, '0, "R4");
    // negative full scale
    for (int i = 0; i < 12; i++) cyc(1, 24'h800000, 0, 0, '0, "R2");
    // R8: updates with user path selected
    for (int i = 0; i < 8; i++) cyc(1, 24'h7FFFFF, 0, 1, 24'h00BEEF, "R8");
    // R7: clear wins over a strobe
    cyc(1, 24'h400000, 1, 0, '0, "R7");
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, 0, '0, "R7");
    // R3: zero shift acts as one
    k_short = 4'd0; k_long = 4'd0;
    for (int i = 0; i < 6; i++) cyc(1, 24'hFFF000, 0, 0, '0, "R3");
    k_short = 4'd1; k_long = 4'd10;
    cyc(0, '0, 1, 0, '0, "R7");
    for (int i = 0; i < 1100; i++) cyc(1, 24'd5000 + 24'(i), 0, 0, '0, "R5");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        k_short = 4'($urandom_range(0, 15));
        k_long  = 4'($urandom_range(0, 6));
      end
      cyc($urandom_range(0, 3) != 0, 24'($urandom),
          $urandom_range(0, 299) == 0, $urandom_range(0, 1) == 1,
          24'($urandom), "R8");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule